// File: doc/BRIEF.md
# Register Access Lock Controller

This block sits between a simple register bus (address, write data, write strobe, read strobe) and a small configuration register file. After every reset the register file is sealed off. Reads return zero and writes are dropped. The way to open it is to write a secret access code to one fixed unlock address before a timeout window runs out. The window is counted in clock cycles from reset release. Once the window has expired, the lock stays shut until the next reset.

A nonvolatile "seal" bit overrides this path. It is sampled once, in the first clock cycle after reset release, and held for the whole session. When it reads as 1, the block enters a permanent sealed state. In that state no access is ever granted and the code path is dead.

While the block is open, software can write a request bit that is forwarded to the nonvolatile store. That request does not change the lock state of the current session. It only matters after the next reset.

Top module: `cfg_access_guard`

## Requirements
- R1: After reset, `lock_state_o` reads 2'b00 (locked), `bus_rdata_o` is zero and `seal_req_o` is zero. The other encodings are 2'b01 (open) and 2'b10 (sealed), and 2'b11 never appears.
- R2: While the state is not open, a read strobe loads zero into `bus_rdata_o`, and writes to any register are discarded. A value written while locked is not visible after the block opens.
- R3: A write to address 0x24 with `bus_wdata_i[29:0]` equal to `ACCESS_CODE` opens the block. The condition is that the write lands on clock edge 2 through `WINDOW_CYCLES` after reset release. `lock_state_o` shows 2'b01 one cycle after that edge.
- R4: Bits 31:30 of the unlock write are ignored by the code comparison.
- R5: A write to 0x24 with a mismatching code leaves the block locked. A later correct code inside the window still opens it.
- R6: A correct code on edge `WINDOW_CYCLES` is accepted. A correct code on any later edge is refused, and the block stays locked until reset.
- R7: While open, a write to register address n (0 to `NREGS`-1) stores the data. A read strobe at that address returns the stored value on `bus_rdata_o` on the next cycle. Reads of unmapped addresses return zero.
- R8: While open, a write to 0x20 sets `seal_req_o` to `bus_wdata_i[0]`, and a read of 0x20 returns it in bit 0. Setting it leaves the state open.
- R9: If `nv_seal_i` is 1 on the first edge after reset release, the state becomes 2'b10 and stays there. Correct codes are refused, reads return zero and writes are discarded.
- R10: A reset always returns the block to locked, with registers cleared, even after it was opened.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nv_seal_i | input | 1 | Stored permanent seal bit from nonvolatile memory |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_rdata_o | output | DATA_W | Registered read data |
| lock_state_o | output | 2 | Lock status: 00 locked, 01 open, 10 sealed |
| seal_req_o | output | 1 | Seal request to be stored in nonvolatile memory |

## Verification
The bench aims the correct code at the last accepted edge of the window and at the first refused edge. A counter that is off by one would open too late or refuse a code it should take. It writes registers while locked and reads them after opening. Gating that leaked writes would show the stale value. It checks that a code with junk in its top bits still opens the lock, and that a wrong code does not burn the window. It sets the seal request and confirms the session stays open. A design that acted on the request at once would lock the bus mid-session. It reboots with the stored seal bit set, where a design that still honoured the code would reopen.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;

  typedef enum logic [1:0] {
    GST_LOCKED = 2'b00,
    GST_OPEN   = 2'b01,
    GST_SEALED = 2'b10
  } guard_state_e;

endpackage

// File: rtl/guard_window_timer.sv
module guard_window_timer #(
  parameter int WINDOW_CYCLES = 8000
) (
  input  logic clk,
  input  logic rst_n,
  output logic expired_o
);

  localparam int CW = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          exp_q, exp_d;
  logic          tick_en;

  assign tick_en = !exp_q;

  always_comb begin
    cnt_d = cnt_q;
    exp_d = exp_q;
    if (tick_en) begin
      if (cnt_q == LAST) begin
        exp_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      exp_q <= 1'b0;
    end else if (tick_en) begin
      cnt_q <= cnt_d;
      exp_q <= exp_d;
    end
  end

  assign expired_o = exp_q;

endmodule

// File: rtl/guard_lock_fsm.sv
module guard_lock_fsm
  import cfg_guard_pkg::*;
#(
  parameter int              DATA_W      = 32,
  parameter int              ADDR_W      = 8,
  parameter int              CODE_W      = 30,
  parameter logic [ADDR_W-1:0] UNLOCK_ADDR = 8'h24,
  parameter logic [CODE_W-1:0] ACCESS_CODE = 30'h1A5C3E17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nv_seal_i,
  input  logic              win_expired_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output guard_state_e      state_o
);

  guard_state_e state_q, state_d;
  logic         armed_q;
  logic         code_ok;
  logic         try_unlock;

  assign code_ok    = (wdata_i[CODE_W-1:0] == ACCESS_CODE);
  assign try_unlock = armed_q && wr_i && (addr_i == UNLOCK_ADDR) && !win_expired_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      GST_LOCKED: begin
        if (!armed_q) begin
          state_d = nv_seal_i ? GST_SEALED : GST_LOCKED;
        end else if (try_unlock && code_ok) begin
          state_d = GST_OPEN;
        end
      end
      GST_OPEN:   state_d = GST_OPEN;
      GST_SEALED: state_d = GST_SEALED;
      default:    state_d = GST_LOCKED;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= GST_LOCKED;
      armed_q <= 1'b0;
    end else begin
      state_q <= state_d;
      armed_q <= 1'b1;
    end
  end

  assign state_o = state_q;

endmodule

// File: rtl/guard_regfile.sv
module guard_regfile #(
  parameter int                DATA_W    = 32,
  parameter int                ADDR_W    = 8,
  parameter int                NREGS     = 8,
  parameter logic [ADDR_W-1:0] SEAL_ADDR = 8'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              open_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              seal_req_o
);

  logic [DATA_W-1:0] word [NREGS];
  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              seal_q, seal_d;
  logic              seal_we;
  logic              bus_wr_ok;

  assign bus_wr_ok = open_i && wr_i;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic [DATA_W-1:0] q_r, d_r;
    logic              we_r;

    assign we_r = bus_wr_ok && (addr_i == ADDR_W'(g));

    always_comb begin
      d_r = q_r;
      if (we_r) d_r = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_r <= '0;
      else if (we_r) q_r <= d_r;
    end

    assign word[g] = q_r;
  end

  assign seal_we = bus_wr_ok && (addr_i == SEAL_ADDR);

  always_comb begin
    seal_d = seal_q;
    if (seal_we) seal_d = wdata_i[0];
  end

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (addr_i == ADDR_W'(i)) rd_val = word[i];
    end
    if (addr_i == SEAL_ADDR) rd_val = {{(DATA_W-1){1'b0}}, seal_q};
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_i) rdata_d = open_i ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
      seal_q  <= 1'b0;
    end else begin
      if (rd_i)    rdata_q <= rdata_d;
      if (seal_we) seal_q  <= seal_d;
    end
  end

  assign rdata_o    = rdata_q;
  assign seal_req_o = seal_q;

endmodule

// File: rtl/cfg_access_guard.sv
module cfg_access_guard
  import cfg_guard_pkg::*;
#(
  parameter int                DATA_W        = 32,
  parameter int                ADDR_W        = 8,
  parameter int                NREGS         = 8,
  parameter int                CODE_W        = 30,
  parameter int                WINDOW_CYCLES = 8000,
  parameter logic [ADDR_W-1:0] UNLOCK_ADDR   = 8'h24,
  parameter logic [ADDR_W-1:0] SEAL_ADDR     = 8'h20,
  parameter logic [CODE_W-1:0] ACCESS_CODE   = 30'h1A5C3E17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nv_seal_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [1:0]        lock_state_o,
  output logic              seal_req_o
);

  logic         win_expired;
  guard_state_e state;
  logic         is_open;

  guard_window_timer #(
    .WINDOW_CYCLES(WINDOW_CYCLES)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .expired_o (win_expired)
  );

  guard_lock_fsm #(
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W),
    .CODE_W      (CODE_W),
    .UNLOCK_ADDR (UNLOCK_ADDR),
    .ACCESS_CODE (ACCESS_CODE)
  ) u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .nv_seal_i     (nv_seal_i),
    .win_expired_i (win_expired),
    .wr_i          (bus_wr_i),
    .addr_i        (bus_addr_i),
    .wdata_i       (bus_wdata_i),
    .state_o       (state)
  );

  assign is_open = (state == GST_OPEN);

  guard_regfile #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .NREGS     (NREGS),
    .SEAL_ADDR (SEAL_ADDR)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .open_i     (is_open),
    .wr_i       (bus_wr_i),
    .rd_i       (bus_rd_i),
    .addr_i     (bus_addr_i),
    .wdata_i    (bus_wdata_i),
    .rdata_o    (bus_rdata_o),
    .seal_req_o (seal_req_o)
  );

  assign lock_state_o = state;

endmodule

// File: rtl/cfg_access_guard_chk.sv
module cfg_access_guard_chk #(
  parameter int                DATA_W      = 32,
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] UNLOCK_ADDR = 8'h24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr_i,
  input logic              bus_rd_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [DATA_W-1:0] bus_rdata_o,
  input logic [1:0]        lock_state_o,
  input logic              win_expired
);

  AST_STATE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    lock_state_o != 2'b11);  // R1

  AST_LOCKED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_i && lock_state_o != 2'b01) |=> bus_rdata_o == '0);  // R2

  AST_OPEN_NEEDS_UNLOCK_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_state_o == 2'b00 && !(bus_wr_i && bus_addr_i == UNLOCK_ADDR)) |=> lock_state_o != 2'b01);  // R5

  AST_NO_OPEN_AFTER_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_state_o == 2'b00 && win_expired) |=> lock_state_o == 2'b00);  // R6

  AST_OPEN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    lock_state_o == 2'b01 |=> lock_state_o == 2'b01);  // R8

  AST_SEALED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    lock_state_o == 2'b10 |=> lock_state_o == 2'b10);  // R9

endmodule

bind cfg_access_guard cfg_access_guard_chk #(
  .DATA_W      (DATA_W),
  .ADDR_W      (ADDR_W),
  .UNLOCK_ADDR (UNLOCK_ADDR)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .bus_wr_i     (bus_wr_i),
  .bus_rd_i     (bus_rd_i),
  .bus_addr_i   (bus_addr_i),
  .bus_rdata_o  (bus_rdata_o),
  .lock_state_o (lock_state_o),
  .win_expired  (win_expired)
);

// File: tb/cfg_access_guard_bench.sv
`timescale 1ns/1ps
module cfg_access_guard_bench;

  localparam int          W     = 40;
  localparam logic [29:0] CODE  = 30'h1A5C3E17;
  localparam logic [7:0]  UNLK  = 8'h24;
  localparam logic [7:0]  SEALA = 8'h20;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        nv_seal;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic        wr, rd;
  logic [31:0] rdata;
  logic [1:0]  lstate;
  logic        sreq;

  always #2 clk = ~clk;

  cfg_access_guard #(.WINDOW_CYCLES(W), .ACCESS_CODE(CODE)) u_cfg_access_guard (
    .clk(clk), .rst_n(rst_n), .nv_seal_i(nv_seal),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_rdata_o(rdata), .lock_state_o(lstate), .seal_req_o(sreq)
  );

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";

  // behavioural reference model
  int          m_edge;
  logic [1:0]  m_state;
  logic        m_armed;
  logic [31:0] m_regs [8];
  logic [31:0] m_rdata;
  logic        m_seal;

  function automatic logic [31:0] mread(input logic [7:0] a);
    if (a < 8) return m_regs[a[2:0]];
    if (a == SEALA) return {31'd0, m_seal};
    return 32'd0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_edge = 0; m_state = 2'b00; m_armed = 1'b0; m_rdata = 0; m_seal = 1'b0;
      for (int i = 0; i < 8; i++) m_regs[i] = 0;
    end else begin
      m_edge++;
      if (rd) m_rdata = (m_state == 2'b01) ? mread(addr) : 32'd0;
      if (!m_armed) begin
        m_armed = 1'b1;
        if (nv_seal) m_state = 2'b10;
      end else begin
        if (wr && m_state == 2'b01) begin
          if (addr < 8) m_regs[addr[2:0]] = wdata;
          else if (addr == SEALA) m_seal = wdata[0];
        end
        if (m_state == 2'b00 && wr && addr == UNLK && m_edge <= W && wdata[29:0] == CODE)
          m_state = 2'b01;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp_model();
    chk({cur_req, " state"}, {30'd0, lstate}, {30'd0, m_state});
    chk({cur_req, " rdata"}, rdata, m_rdata);
    chk({cur_req, " seal_req"}, {31'd0, sreq}, {31'd0, m_seal});
  endtask

  task automatic cyc(input logic w, input logic r, input logic [7:0] a, input logic [31:0] d);
    wr = w; rd = r; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk);
    wr = 0; rd = 0;
    cmp_model();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 32'd0);
  endtask

  task automatic do_reset(input logic nv);
    @(negedge clk);
    rst_n = 0; wr = 0; rd = 0; addr = 0; wdata = 0; nv_seal = nv;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  bit done = 0;
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; nv_seal = 0; wr = 0; rd = 0; addr = 0; wdata = 0;
    do_reset(1'b0);
    // R1 reset state
    cur_req = "R1";
    chk("R1 state", {30'd0, lstate}, 32'd0);
    chk("R1 rdata", rdata, 32'd0);
    chk("R1 seal_req", {31'd0, sreq}, 32'd0);
    idle(2);
    // R2 locked accesses
    cur_req = "R2";
    cyc(1, 0, 8'h03, 32'hDEAD_BEEF);
    cyc(0, 1, 8'h03, 32'd0);
    chk("R2 locked read", rdata, 32'd0);
    // R5 wrong code keeps it closed
    cur_req = "R5";
    cyc(1, 0, UNLK, {2'b00, CODE ^ 30'h1});
    chk("R5 still locked", {30'd0, lstate}, 32'd0);
    // R4 upper bits ignored, R3 correct code opens
    cur_req = "R3";
    cyc(1, 0, UNLK, {2'b11, CODE});
    chk("R3 R4 opened", {30'd0, lstate}, 32'd1);
    cyc(0, 1, 8'h03, 32'd0);
    chk("R2 locked write discarded", rdata, 32'd0);
    // R7 register storage while open
    cur_req = "R7";
    cyc(1, 0, 8'h03, 32'hCAFE_0123);
    cyc(1, 0, 8'h07, 32'h0BAD_F00D);
    cyc(0, 1, 8'h03, 32'd0);
    chk("R7 readback 3", rdata, 32'hCAFE_0123);
    cyc(0, 1, 8'h07, 32'd0);
    chk("R7 readback 7", rdata, 32'h0BAD_F00D);
    cyc(0, 1, 8'h11, 32'd0);
    chk("R7 unmapped", rdata, 32'd0);
    // R8 seal request does not end session
    cur_req = "R8";
    cyc(1, 0, SEALA, 32'h1);
    chk("R8 seal_req", {31'd0, sreq}, 32'd1);
    chk("R8 still open", {30'd0, lstate}, 32'd1);
    cyc(0, 1, SEALA, 32'd0);
    chk("R8 readback", rdata, 32'd1);
    // R10 reset re-arms lock
    cur_req = "R10";
    do_reset(1'b0);
    idle(1);
    chk("R10 relocked", {30'd0, lstate}, 32'd0);
    chk("R10 seal_req cleared", {31'd0, sreq}, 32'd0);
    // R6 code one edge late is refused
    cur_req = "R6";
    idle(W - 1);
    cyc(1, 0, UNLK, {2'b00, CODE});
    chk("R6 late refused", {30'd0, lstate}, 32'd0);
    idle(3);
    // R6 code on last window edge accepted
    do_reset(1'b0);
    idle(W - 1);
    cyc(1, 0, UNLK, {2'b00, CODE});
    chk("R6 last edge accepted", {30'd0, lstate}, 32'd1);
    cyc(0, 1, 8'h03, 32'd0);
    chk("R10 regs cleared", rdata, 32'd0);
    // R9 stored seal bit
    cur_req = "R9";
    do_reset(1'b1);
    idle(1);
    chk("R9 sealed", {30'd0, lstate}, 32'd2);
    cyc(1, 0, UNLK, {2'b00, CODE});
    chk("R9 code refused", {30'd0, lstate}, 32'd2);
    cyc(1, 0, 8'h02, 32'h1234_5678);
    cyc(0, 1, 8'h02, 32'd0);
    chk("R9 read zero", rdata, 32'd0);
    idle(4);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule